// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block gathers six active-low interrupt request lines, turns a falling edge on each line into a pending bit, and presents one winning source to a processor. Each source has an individual enable, and a global enable gates all of them. A request stays latched whether or not it is enabled, so software can also poll the request register and service sources without taking an interrupt.

When more than one eligible request is pending, a programmable scheme picks the winner. The six sources are split into three fixed pairs. One bit per pair picks which member of that pair wins. A 3-bit code sets the order of the three pairs. When the processor acknowledges, the block returns the source number and the program address of that source's vector slot. It clears the granted pending bit and the global enable, and pulses a flag so that the processor's own logic also knows interrupts are now off.

Top module: `prio_intc`

## Requirements
- R1: After reset the request and mask registers are zero, the priority register holds group-order code 000, and int_req, grant_valid and gie_clr are low.
- R2: A high-to-low transition on irq_n[n] sets request bit n two clock edges after the sample that first sees it low. A line held low, a line held high and a rising transition set nothing.
- R3: The request register sits at address 0, with bit n for source n (bits 5:0). A write stores the written bits, so writing 1 sets a request. A pending bit stays set regardless of the mask.
- R4: The mask register sits at address 1. Bit n (n=0..5) enables source n and bit 7 is the global enable. A source is eligible only when its request bit, its enable bit and the global enable are all set. Bit 6 reads as 0.
- R5: The priority register sits at address 2 and is write-only; it reads as 0. Bits 2:0 hold the group-order code, with pair A = sources 3 and 5, pair B = sources 0 and 2, pair C = sources 1 and 4. Code 001 gives C>A>B, 010 gives A>B>C, 011 gives A>C>B, 100 gives B>C>A, 101 gives C>B>A, and 110 gives B>A>C.
- R6: Bit 3 of the priority register orders pair A: 0 puts source 5 above 3, and 1 puts 3 above 5. Bit 4 orders pair B: 0 puts 2 above 0, and 1 puts 0 above 2. Bit 5 orders pair C: 0 puts 1 above 4, and 1 puts 4 above 1.
- R7: Under group-order code 000 or 111, int_req stays low and an acknowledge grants nothing.
- R8: int_req is high one cycle after the register state holds at least one eligible source under a valid code, and low one cycle after it holds none.
- R9: An acknowledge (ack high for one cycle) while a winner exists makes grant_valid high for the next cycle. In that cycle grant_id holds the winning source n and grant_vec holds 2n, the address of the vector's upper byte.
- R10: A grant clears the granted source's request bit and mask bit 7 in the same edge, and raises gie_clr together with grant_valid.
- R11: An acknowledge with no eligible source leaves grant_valid low and the request and mask registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_n | input | 6 | Active-low request lines, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 request, 1 mask, 2 priority |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data for reg_addr of the previous cycle |
| int_req | output | 1 | An eligible source is pending |
| ack | input | 1 | Processor acknowledge strobe |
| grant_valid | output | 1 | One-cycle grant pulse |
| grant_id | output | 3 | Granted source number |
| grant_vec | output | 16 | Program address of the vector's upper byte |
| gie_clr | output | 1 | Pulse telling the processor the global enable was cleared |

## Verification
The assertions assume that ack is a single-cycle strobe from a processor that only acknowledges after seeing int_req. They also assume that no register write lands in the same cycle as an acknowledge: a same-cycle mask write could otherwise race the global-enable clear they check. The stimulus keeps to this. Every write, acknowledge and line change is driven on the falling clock edge, one operation at a time. The request lines are changed only in dedicated phases, while no acknowledge is in flight.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  localparam int NSRC   = 6;
  localparam int NGRP   = 3;
  localparam int ID_W   = 3;
  localparam int CODE_W = 3;

  typedef enum logic [1:0] {
    ADDR_REQ  = 2'd0,
    ADDR_MASK = 2'd1,
    ADDR_PRIO = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;

  // Group indices: A = sources 3/5, B = sources 0/2, C = sources 1/4.
  localparam logic [1:0] GRP_A = 2'd0;
  localparam logic [1:0] GRP_B = 2'd1;
  localparam logic [1:0] GRP_C = 2'd2;

  typedef struct packed {
    logic       valid;
    logic [1:0] first;
    logic [1:0] second;
    logic [1:0] third;
  } grp_order_t;

  // Source that wins a group when its select bit is 0.
  function automatic int grp_default_src(input int g);
    case (g)
      0:       return 5;
      1:       return 2;
      default: return 1;
    endcase
  endfunction

  // Source that wins a group when its select bit is 1.
  function automatic int grp_alt_src(input int g);
    case (g)
      0:       return 3;
      1:       return 0;
      default: return 4;
    endcase
  endfunction

  function automatic grp_order_t decode_order(input logic [CODE_W-1:0] code);
    grp_order_t o;
    o = '{valid: 1'b1, first: GRP_A, second: GRP_B, third: GRP_C};
    case (code)
      3'b001: begin o.first = GRP_C; o.second = GRP_A; o.third = GRP_B; end
      3'b010: begin o.first = GRP_A; o.second = GRP_B; o.third = GRP_C; end
      3'b011: begin o.first = GRP_A; o.second = GRP_C; o.third = GRP_B; end
      3'b100: begin o.first = GRP_B; o.second = GRP_C; o.third = GRP_A; end
      3'b101: begin o.first = GRP_C; o.second = GRP_B; o.third = GRP_A; end
      3'b110: begin o.first = GRP_B; o.second = GRP_A; o.third = GRP_C; end
      default: o.valid = 1'b0;
    endcase
    return o;
  endfunction
endpackage

// File: rtl/prio_intc_edge.sv
module prio_intc_edge #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] line_n,
  output logic [WIDTH-1:0] fall
);
  localparam int DEPTH = STAGES + 1;

  // pipe[0..STAGES-1] synchronise, pipe[STAGES] holds the previous value.
  logic [WIDTH-1:0] pipe [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) pipe[i] <= '1;
    end else begin
      pipe[0] <= line_n;
      for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
    end
  end

  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_fall
      assign fall[b] = pipe[STAGES][b] & ~pipe[STAGES-1][b];
    end
  endgenerate
endmodule

// File: rtl/prio_intc_pair.sv
module prio_intc_pair #(
  parameter int SRC_X = 0,
  parameter int SRC_Y = 1,
  parameter int ID_W  = 3
) (
  input  logic            elig_x,
  input  logic            elig_y,
  input  logic            y_first,
  output logic            any,
  output logic [ID_W-1:0] id
);
  localparam logic [ID_W-1:0] ID_X = ID_W'(SRC_X);
  localparam logic [ID_W-1:0] ID_Y = ID_W'(SRC_Y);

  always_comb begin
    any = elig_x | elig_y;
    if (y_first) id = elig_y ? ID_Y : ID_X;
    else         id = elig_x ? ID_X : ID_Y;
  end
endmodule

// File: rtl/prio_intc_resolve.sv
module prio_intc_resolve
  import prio_intc_pkg::*;
(
  input  logic [NSRC-1:0]   elig,
  input  logic [CODE_W-1:0] code,
  input  logic [NGRP-1:0]   pair_sel,
  output logic              win_valid,
  output logic [ID_W-1:0]   win_id
);
  logic [NGRP-1:0] grp_any;
  logic [ID_W-1:0] grp_id [NGRP];
  grp_order_t      ord;

  genvar g;
  generate
    for (g = 0; g < NGRP; g++) begin : g_pair
      localparam int SX = grp_default_src(g);
      localparam int SY = grp_alt_src(g);
      prio_intc_pair #(.SRC_X(SX), .SRC_Y(SY), .ID_W(ID_W)) u_pair (
        .elig_x  (elig[SX]),
        .elig_y  (elig[SY]),
        .y_first (pair_sel[g]),
        .any     (grp_any[g]),
        .id      (grp_id[g])
      );
    end
  endgenerate

  always_comb begin
    ord       = decode_order(code);
    win_valid = 1'b0;
    win_id    = '0;
    if (ord.valid) begin
      if (grp_any[ord.first]) begin
        win_valid = 1'b1;
        win_id    = grp_id[ord.first];
      end else if (grp_any[ord.second]) begin
        win_valid = 1'b1;
        win_id    = grp_id[ord.second];
      end else if (grp_any[ord.third]) begin
        win_valid = 1'b1;
        win_id    = grp_id[ord.third];
      end
    end
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8,
  parameter int VEC_W       = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   irq_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              int_req,
  input  logic              ack,
  output logic              grant_valid,
  output logic [ID_W-1:0]   grant_id,
  output logic [VEC_W-1:0]  grant_vec,
  output logic              gie_clr
);
  localparam int GIE_BIT = DATA_W - 1;
  localparam int SEL_LSB = CODE_W;

  logic [NSRC-1:0]   req_q, en_q, edge_set, elig_w;
  logic              gie_q;
  logic [CODE_W-1:0] code_q;
  logic [NGRP-1:0]   sel_q;
  logic              win_valid;
  logic [ID_W-1:0]   win_id;
  logic              grant_fire;
  logic              code_rsv_w;
  logic              wr_req, wr_mask, wr_prio;

  prio_intc_edge #(.WIDTH(NSRC), .STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .line_n (irq_n),
    .fall   (edge_set)
  );

  assign elig_w     = req_q & en_q & {NSRC{gie_q}};
  assign code_rsv_w = (code_q == '0) || (code_q == '1);

  prio_intc_resolve u_resolve (
    .elig      (elig_w),
    .code      (code_q),
    .pair_sel  (sel_q),
    .win_valid (win_valid),
    .win_id    (win_id)
  );

  assign grant_fire = ack & win_valid;
  assign wr_req     = reg_wr && (reg_addr == ADDR_REQ);
  assign wr_mask    = reg_wr && (reg_addr == ADDR_MASK);
  assign wr_prio    = reg_wr && (reg_addr == ADDR_PRIO);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= '0;
    end else begin
      logic [NSRC-1:0] nx;
      nx = req_q;
      if (wr_req) nx = reg_wdata[NSRC-1:0];
      if (grant_fire) nx[win_id] = 1'b0;
      req_q <= nx | edge_set;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      gie_q <= 1'b0;
    end else begin
      if (wr_mask) begin
        en_q  <= reg_wdata[NSRC-1:0];
        gie_q <= reg_wdata[GIE_BIT];
      end
      if (grant_fire) gie_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      sel_q  <= '0;
    end else if (wr_prio) begin
      code_q <= reg_wdata[CODE_W-1:0];
      sel_q  <= reg_wdata[SEL_LSB +: NGRP];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        ADDR_REQ:  reg_rdata <= DATA_W'(req_q);
        ADDR_MASK: reg_rdata <= {gie_q, {(DATA_W-1-NSRC){1'b0}}, en_q};
        default:   reg_rdata <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      int_req     <= 1'b0;
      grant_valid <= 1'b0;
      grant_id    <= '0;
      grant_vec   <= '0;
      gie_clr     <= 1'b0;
    end else begin
      int_req     <= win_valid;
      grant_valid <= grant_fire;
      gie_clr     <= grant_fire;
      if (grant_fire) begin
        grant_id  <= win_id;
        grant_vec <= VEC_W'(win_id) << 1;
      end
    end
  end
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk
  import prio_intc_pkg::*;
#(
  parameter int VEC_W = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            int_req,
  input logic            grant_valid,
  input logic [ID_W-1:0] grant_id,
  input logic [VEC_W-1:0] grant_vec,
  input logic            gie,
  input logic [NSRC-1:0] elig,
  input logic            code_rsv
);
  // R10: a grant leaves the global enable cleared
  assert_gie_cleared_R10: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> !gie);

  // R4: a granted source was eligible in the cycle of the acknowledge
  assert_grant_eligible_R4: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> ((($past(elig) >> grant_id) & 6'd1) != 6'd0));

  // R7: reserved order code never raises a request
  assert_reserved_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    code_rsv |=> !int_req);

  // R8: int_req only follows a state with the global enable set
  assert_req_needs_gie_R8: assert property (@(posedge clk) disable iff (rst)
    int_req |-> $past(gie));

  // R9: granted number is a real source and the vector slot is even
  assert_grant_range_R9: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> (grant_id < ID_W'(NSRC)) && !grant_vec[0]);
endmodule

bind prio_intc prio_intc_chk #(.VEC_W(VEC_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .int_req     (int_req),
  .grant_valid (grant_valid),
  .grant_id    (grant_id),
  .grant_vec   (grant_vec),
  .gie         (gie_q),
  .elig        (elig_w),
  .code_rsv    (code_rsv_w)
);

// File: tb/prio_intc_tb.sv
module prio_intc_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  irq_n = '1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        int_req;
  logic        ack = 1'b0;
  logic        grant_valid;
  logic [2:0]  grant_id;
  logic [15:0] grant_vec;
  logic        gie_clr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  prio_intc u_dut (
    .clk(clk), .rst(rst), .irq_n(irq_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .int_req(int_req), .ack(ack),
    .grant_valid(grant_valid), .grant_id(grant_id), .grant_vec(grant_vec),
    .gie_clr(gie_clr)
  );

  task automatic check(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    reg_addr = a;
    @(negedge clk);
    v = int'(reg_rdata);
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  // Expected winner from R5/R6: -1 when none.
  function automatic int model(input int code, input int sel, input int elig);
    int ord[3];
    int hi, lo;
    case (code)
      1: ord = '{2, 0, 1};
      2: ord = '{0, 1, 2};
      3: ord = '{0, 2, 1};
      4: ord = '{1, 2, 0};
      5: ord = '{2, 1, 0};
      6: ord = '{1, 0, 2};
      default: return -1;
    endcase
    for (int k = 0; k < 3; k++) begin
      case (ord[k])
        0: begin hi = sel[0] ? 3 : 5; lo = sel[0] ? 5 : 3; end
        1: begin hi = sel[1] ? 0 : 2; lo = sel[1] ? 2 : 0; end
        default: begin hi = sel[2] ? 4 : 1; lo = sel[2] ? 1 : 4; end
      endcase
      if (elig[hi]) return hi;
      if (elig[lo]) return lo;
    end
    return -1;
  endfunction

  initial begin
    int v, w;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 int_req", int'(int_req), 0);
    check("R1 grant_valid", int'(grant_valid), 0);
    check("R1 gie_clr", int'(gie_clr), 0);
    rd(2'd0, v); check("R1 request reg", v, 0);
    rd(2'd1, v); check("R1 mask reg", v, 0);
    // R7 reset code 000: nothing granted even with everything enabled
    wr(2'd1, 8'hBF); wr(2'd0, 8'h3F); @(negedge clk);
    check("R7 reset code int_req", int'(int_req), 0);
    pulse_ack();
    check("R7 reset code grant", int'(grant_valid), 0);
    // R11 no change after empty ack
    rd(2'd0, v); check("R11 request kept", v, 8'h3F);
    rd(2'd1, v); check("R11 mask kept", v, 8'hBF);
    // R7 code 111
    wr(2'd2, 8'h07); @(negedge clk);
    check("R7 code 111 int_req", int'(int_req), 0);
    pulse_ack();
    check("R7 code 111 grant", int'(grant_valid), 0);
    // R5 priority register reads 0
    rd(2'd2, v); check("R5 prio reads zero", v, 0);
    rd(2'd3, v); check("R5 unused addr reads zero", v, 0);
    // R4 individual enables off, global on: no request, pending kept (R3)
    wr(2'd2, 8'h02); wr(2'd1, 8'h80); @(negedge clk);
    check("R4 enables off int_req", int'(int_req), 0);
    wr(2'd1, 8'h3F); @(negedge clk);
    check("R4 global off int_req", int'(int_req), 0);
    rd(2'd1, v); check("R4 bit6 reads zero", v, 8'h3F);
    wr(2'd1, 8'hFF); rd(2'd1, v); check("R4 bit6 ignored", v, 8'hBF);
    rd(2'd0, v); check("R3 pending survives mask", v, 8'h3F);
    wr(2'd1, 8'h00);
    // R11 ack with eligible none
    wr(2'd0, 8'h00); pulse_ack();
    check("R11 empty ack", int'(grant_valid), 0);
    // R2 edge detection
    for (int s = 0; s < 6; s++) begin
      wr(2'd0, 8'h00);
      irq_n[s] = 1'b0;
      @(negedge clk);
      rd(2'd0, v); check("R2 not yet set", v, 0);
      @(negedge clk);
      rd(2'd0, v); check("R2 fall sets bit", v, 1 << s);
      wr(2'd0, 8'h00); @(negedge clk); @(negedge clk);
      rd(2'd0, v); check("R2 held low no reset", v, 0);
      irq_n[s] = 1'b1;
      repeat (4) @(negedge clk);
      rd(2'd0, v); check("R2 rise ignored", v, 0);
    end
    // R5 R6 R8 R9 R10 sweep
    for (int code = 1; code <= 6; code++) begin
      for (int sel = 0; sel < 8; sel++) begin
        wr(2'd2, 8'(code | (sel << 3)));
        for (int pat = 1; pat < 64; pat++) begin
          int exp_id;
          exp_id = model(code, sel, pat);
          wr(2'd1, 8'hBF);
          wr(2'd0, 8'(pat));
          @(negedge clk);
          check("R8 int_req", int'(int_req), 1);
          pulse_ack();
          check("R9 grant_valid", int'(grant_valid), 1);
          check("R5 R6 grant_id", int'(grant_id), exp_id);
          check("R9 grant_vec", int'(grant_vec), 2 * exp_id);
          check("R10 gie_clr", int'(gie_clr), 1);
          rd(2'd0, w);
          check("R10 request cleared", w, pat & ~(1 << exp_id));
          rd(2'd1, v);
          check("R10 gie cleared", v, 8'h3F);
          check("R8 int_req drops", int'(int_req), 0);
        end
      end
    end
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    end
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule